// File: doc/BRIEF.md
# Per-Frame CRC-6 Generator and Checker

This block keeps a CRC-6 per frame for the two directions of a framed serial link. Each bit comes with a valid strobe, a frame-start marker and a two-bit tag that says which field it belongs to. Only payload-tagged bits feed the calculation. Sync, stuff and CRC-field bits pass by without touching the register.

On the transmit side, the block closes the running CRC at every frame start and holds it for the framer to insert into the frame that has just begun. On the receive side, it closes and stores the CRC of each frame in the same way. It then gathers the CRC field of the following frame and compares it with the stored value.

A mismatch gives a one-clock error pulse. It also latches a far-end error request, which marks the next transmit frame. Framing, bit insertion and extraction are left to neighbouring blocks.

Top module: `frame_crc6_unit`

## Requirements
- R1: At each transmit bit with valid and frame start high, `tx_crc_word` takes the CRC of the transmit frame that just ended and holds it until the next transmit frame start. The CRC uses generator x^6 + x + 1 (low-order taps 6'h03), starts from zero, and takes bits in arrival order as most significant first.
- R2: Only bits with valid high and tag 2'b00 (payload) enter the CRC. Bits tagged 2'b01 (sync), 2'b10 (stuff) or 2'b11 (CRC field), and any bit with valid low, leave the result unchanged.
- R3: The CRC register restarts from zero at every frame start, so a frame's CRC does not depend on earlier frames; an all-zero payload gives 6'h00.
- R4: `tx_crc_valid` stays low from reset until the second transmit frame start. No receive comparison is made in the first receive frame after reset.
- R5: In each receive frame from the second on, the first six CRC-tagged bits (most significant first) are compared with the stored CRC of the previous receive frame. On mismatch, `crc_error` is high for exactly the one cycle after the sixth such bit. On a match it stays low.
- R6: CRC-tagged receive bits beyond the sixth in a frame are ignored.
- R7: A receive mismatch is latched as a pending request. At the next transmit frame start, `febe_req` takes the pending value and holds it for that whole transmit frame. It falls at a later transmit frame start if no mismatch arrived in between.
- R8: After reset, `crc_error`, `febe_req`, `tx_crc_valid` and `tx_crc_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit | input | 1 | Transmit serial bit |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_sof | input | 1 | Transmit bit is the first of a frame |
| tx_kind | input | 2 | Transmit field tag: 00 payload, 01 sync, 10 stuff, 11 CRC |
| rx_bit | input | 1 | Receive serial bit |
| rx_valid | input | 1 | Receive bit strobe |
| rx_sof | input | 1 | Receive bit is the first of a frame |
| rx_kind | input | 2 | Receive field tag, same coding as tx_kind |
| tx_crc_word | output | CRC_W | CRC of the previous transmit frame, for insertion |
| tx_crc_valid | output | 1 | tx_crc_word holds a completed frame's CRC |
| crc_error | output | 1 | One-cycle receive mismatch pulse |
| febe_req | output | 1 | Far-end error flag for the current transmit frame |

## Verification
The bench builds the block with its default parameters: a 6-bit CRC with taps 6'h03. A reference model in the bench computes the CRC of each payload. With six-bit fields, a frame fits in a few dozen cycles. This makes the first-frame suppression, the exact pulse cycle after the sixth CRC bit, surplus CRC bits and the hand-off of the far-end flag at a transmit frame start all reachable in short directed frames.

// File: rtl/frame_crc6_pkg.sv
package frame_crc6_pkg;
    typedef enum logic [1:0] {
        KIND_DATA  = 2'b00,
        KIND_SYNC  = 2'b01,
        KIND_STUFF = 2'b10,
        KIND_CRC   = 2'b11
    } bit_kind_e;
endpackage

// File: rtl/frame_crc6_accum.sv
module frame_crc6_accum
    import frame_crc6_pkg::*;
#(
    parameter int unsigned           CRC_W = 6,
    parameter logic [CRC_W-1:0]      POLY  = 'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             valid,
    input  logic             sof,
    input  logic [1:0]       kind,
    output logic [CRC_W-1:0] held_crc,
    output logic             held_ok
);
    typedef struct packed {
        logic [CRC_W-1:0] run;
        logic [CRC_W-1:0] held;
        logic             ok;
        logic             active;
    } acc_t;

    acc_t st_q, st_d;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

    always_comb begin
        logic [CRC_W-1:0] base;
        st_d = st_q;
        base = sof ? '0 : st_q.run;
        if (valid) begin
            if (sof && st_q.active) begin
                st_d.held = st_q.run;
                st_d.ok   = 1'b1;
            end
            if (sof) st_d.active = 1'b1;
            st_d.run = (kind == KIND_DATA) ? crc_step(base, bit_in) : base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_crc = st_q.held;
    assign held_ok  = st_q.ok;
endmodule

// File: rtl/frame_crc6_field_cmp.sv
module frame_crc6_field_cmp
    import frame_crc6_pkg::*;
#(
    parameter int unsigned CRC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             valid,
    input  logic             sof,
    input  logic [1:0]       kind,
    input  logic [CRC_W-1:0] ref_crc,
    input  logic             ref_ok,
    output logic             mismatch
);
    localparam int unsigned CW = $clog2(CRC_W + 1);

    typedef struct packed {
        logic [CRC_W-1:0] sh;
        logic [CW-1:0]    cnt;
        logic             err;
    } cmp_t;

    cmp_t st_q, st_d;

    always_comb begin
        logic [CRC_W-1:0] sh_base;
        logic [CW-1:0]    cnt_base;
        logic [CRC_W-1:0] word;
        st_d     = st_q;
        st_d.err = 1'b0;
        sh_base  = sof ? '0 : st_q.sh;
        cnt_base = sof ? '0 : st_q.cnt;
        word     = {sh_base[CRC_W-2:0], bit_in};
        if (valid) begin
            st_d.sh  = sh_base;
            st_d.cnt = cnt_base;
            if (kind == KIND_CRC && cnt_base < CW'(CRC_W)) begin
                st_d.sh  = word;
                st_d.cnt = cnt_base + 1'b1;
                if (cnt_base == CW'(CRC_W - 1) && ref_ok && word != ref_crc)
                    st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mismatch = st_q.err;
endmodule

// File: rtl/frame_crc6_unit.sv
module frame_crc6_unit #(
    parameter int unsigned      CRC_W = 6,
    parameter logic [CRC_W-1:0] POLY  = 'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_bit,
    input  logic             tx_valid,
    input  logic             tx_sof,
    input  logic [1:0]       tx_kind,
    input  logic             rx_bit,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [1:0]       rx_kind,
    output logic [CRC_W-1:0] tx_crc_word,
    output logic             tx_crc_valid,
    output logic             crc_error,
    output logic             febe_req
);
    logic [CRC_W-1:0] rx_held;
    logic             rx_held_ok;

    frame_crc6_accum #(.CRC_W(CRC_W), .POLY(POLY)) u_tx_acc (
        .clk(clk), .rst_n(rst_n), .bit_in(tx_bit), .valid(tx_valid),
        .sof(tx_sof), .kind(tx_kind),
        .held_crc(tx_crc_word), .held_ok(tx_crc_valid)
    );

    frame_crc6_accum #(.CRC_W(CRC_W), .POLY(POLY)) u_rx_acc (
        .clk(clk), .rst_n(rst_n), .bit_in(rx_bit), .valid(rx_valid),
        .sof(rx_sof), .kind(rx_kind),
        .held_crc(rx_held), .held_ok(rx_held_ok)
    );

    frame_crc6_field_cmp #(.CRC_W(CRC_W)) u_rx_cmp (
        .clk(clk), .rst_n(rst_n), .bit_in(rx_bit), .valid(rx_valid),
        .sof(rx_sof), .kind(rx_kind),
        .ref_crc(rx_held), .ref_ok(rx_held_ok), .mismatch(crc_error)
    );

    typedef struct packed {
        logic pend;
        logic febe;
    } fe_t;

    fe_t fe_q, fe_d;

    always_comb begin
        fe_d = fe_q;
        if (tx_valid && tx_sof) begin
            fe_d.febe = fe_q.pend | crc_error;
            fe_d.pend = 1'b0;
        end else begin
            fe_d.pend = fe_q.pend | crc_error;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= '0;
        else        fe_q <= fe_d;
    end

    assign febe_req = fe_q.febe;
endmodule

// File: rtl/frame_crc6_chk.sv
module frame_crc6_chk #(
    parameter int unsigned CRC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic             tx_sof,
    input logic [CRC_W-1:0] tx_crc_word,
    input logic             tx_crc_valid,
    input logic             crc_error,
    input logic             febe_req
);
    // R1
    tx_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_sof) |=> $stable(tx_crc_word));

    // R4
    tx_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_crc_valid) |-> $past(tx_valid && tx_sof));

    // R5
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> !crc_error);

    // R7
    febe_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_sof) |=> $stable(febe_req));
endmodule

bind frame_crc6_unit frame_crc6_chk #(.CRC_W(CRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sof(tx_sof),
    .tx_crc_word(tx_crc_word), .tx_crc_valid(tx_crc_valid),
    .crc_error(crc_error), .febe_req(febe_req)
);

// File: tb/tb_frame_crc6_unit.sv
module tb_frame_crc6_unit;
    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit = 1'b0, tx_valid = 1'b0, tx_sof = 1'b0;
    logic rx_bit = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0;
    logic [1:0] tx_kind = 2'b00, rx_kind = 2'b00;
    logic [W-1:0] tx_crc_word;
    logic tx_crc_valid, crc_error, febe_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int err_pulses;
    bit err_at6;
    bit febe_at_sof;

    always #10 clk = ~clk;

    frame_crc6_unit dut (
        .clk(clk), .rst_n(rst_n),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_kind(tx_kind),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_kind(rx_kind),
        .tx_crc_word(tx_crc_word), .tx_crc_valid(tx_crc_valid),
        .crc_error(crc_error), .febe_req(febe_req)
    );

    function automatic logic [W-1:0] ref_crc(input logic [63:0] d, input int n);
        logic [W-1:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = c[W-1] ^ d[i];
            c = {c[W-2:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input bit is_rx, input logic b, input logic [1:0] k,
                        input logic s, input logic v);
        @(negedge clk);
        if (is_rx) begin rx_bit = b; rx_kind = k; rx_sof = s; rx_valid = v; end
        else       begin tx_bit = b; tx_kind = k; tx_sof = s; tx_valid = v; end
        @(posedge clk);
        #1;
        if (crc_error) err_pulses++;
        if (is_rx) begin rx_valid = 1'b0; rx_sof = 1'b0; end
        else       begin tx_valid = 1'b0; tx_sof = 1'b0; end
    endtask

    // Frame: 4 sync bits (sof on the first), ncrc CRC bits, n payload bits, nstuff stuff bits.
    task automatic send_frame(input bit is_rx, input logic [3:0] sync, input logic [7:0] crcf,
                              input int ncrc, input logic [63:0] d, input int n,
                              input int nstuff, input bit gaps);
        err_pulses = 0;
        err_at6 = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            send(is_rx, sync[i], 2'b01, i == 3, 1'b1);
            if (i == 3) febe_at_sof = febe_req;
        end
        for (int i = ncrc - 1; i >= 0; i--) begin
            send(is_rx, crcf[i], 2'b11, 1'b0, 1'b1);
            if (ncrc - i == 6) err_at6 = crc_error;
        end
        for (int i = n - 1; i >= 0; i--) begin
            send(is_rx, d[i], 2'b00, 1'b0, 1'b1);
            if (gaps) send(is_rx, ~d[i], 2'b00, 1'b0, 1'b0);
        end
        for (int i = 0; i < nstuff; i++) send(is_rx, i[0], 2'b10, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        check("R8 crc_error", crc_error, 0);
        check("R8 febe_req", febe_req, 0);
        check("R8 tx_crc_valid", tx_crc_valid, 0);
        check("R8 tx_crc_word", tx_crc_word, 0);
    endtask

    task automatic t_tx_basic();
        logic [63:0] a = 64'hB5A3, b = 64'h3C_9E71;
        send_frame(0, 4'b1010, 8'h00, 6, a, 16, 0, 0);
        check("R4 tx_crc_valid low in first frame", tx_crc_valid, 0);
        send_frame(0, 4'b1010, 8'h00, 6, b, 24, 2, 0);
        check("R4 tx_crc_valid after second sof", tx_crc_valid, 1);
        check("R1 tx crc of frame A held", tx_crc_word, ref_crc(a, 16));
        send_frame(0, 4'b1010, 8'h00, 6, 64'h1, 5, 0, 0);
        check("R1 tx crc of frame B", tx_crc_word, ref_crc(b, 24));
    endtask

    task automatic t_tx_exclude();
        logic [63:0] b = 64'h3C_9E71;
        send_frame(0, 4'b0101, 8'h3F, 6, b, 24, 4, 1);
        send_frame(0, 4'b1111, 8'h15, 6, 64'h0, 20, 0, 0);
        check("R2 overhead, stuff and invalid bits excluded", tx_crc_word, ref_crc(b, 24));
        send_frame(0, 4'b1010, 8'h00, 6, 64'h7, 3, 0, 0);
        check("R3 all-zero payload gives zero", tx_crc_word, 0);
    endtask

    task automatic t_rx();
        logic [63:0] f1 = 64'hA5F0_1234, f2 = 64'h0F0F_77, f3 = 64'hDEAD;
        send_frame(1, 4'b1010, 8'h2A, 6, f1, 32, 0, 0);
        check("R4 no compare in first rx frame", err_pulses, 0);
        send_frame(1, 4'b1010, {2'b00, ref_crc(f1, 32)}, 6, f2, 24, 2, 0);
        check("R5 matching field gives no pulse", err_pulses, 0);
        check("R7 no febe without error", febe_req, 0);
        send_frame(1, 4'b1010, {2'b00, ref_crc(f2, 24) ^ 6'h01}, 6, f3, 16, 0, 1);
        check("R5 pulse right after sixth CRC bit", err_at6, 1);
        check("R5 exactly one pulse", err_pulses, 1);
        check("R7 febe waits for tx frame start", febe_req, 0);
        send_frame(1, 4'b1010, {ref_crc(f3, 16), 2'b10}, 8, 64'h5, 4, 0, 0);
        check("R6 surplus CRC bits ignored", err_pulses, 0);
    endtask

    task automatic t_febe();
        send_frame(0, 4'b1010, 8'h00, 6, 64'h55, 8, 0, 0);
        check("R7 febe set at tx frame start", febe_at_sof, 1);
        check("R7 febe held through tx frame", febe_req, 1);
        send_frame(0, 4'b1010, 8'h00, 6, 64'h55, 8, 0, 0);
        check("R7 febe cleared at next tx frame start", febe_at_sof, 0);
    endtask

    initial begin
        #200000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_tx_basic();
        t_tx_exclude();
        t_rx();
        t_febe();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule